// File: doc/BRIEF.md
# Half-to-Single Precision Widener

This block takes a 16-bit half-precision floating-point word and widens it exactly into a 32-bit single-precision word. Widening never loses information, so the block has no rounding and no sticky logic. Normal values have their exponent rebiased. Subnormal halves are renormalised into single-precision normals. Signed zeros, infinities and NaNs map to their single-precision counterparts. A NaN keeps its payload, and a signalling NaN stays signalling.

Words arrive on a valid/ready stream, one value per beat. Each accepted word appears on the output stream one clock later. The output holds a single register stage whose occupancy is tracked by a two-state machine:
- State `OR_EMPTY` means no word is held.
- State `OR_FULL` means a word is being presented.

The machine has four transitions:
- `EMPTY->FULL` happens when a word is accepted.
- `FULL->FULL` happens on a stall, or on a simultaneous drain and refill.
- `FULL->EMPTY` happens when the held word drains and nothing new arrives.
- `EMPTY->EMPTY` happens when the block is idle.

Back-to-back beats run at full rate. Paired with a ties-to-even single-to-half narrower, the round trip returns every non-NaN half pattern unchanged.

Top module: `half_to_single_widen`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Output bit 31 equals input bit 15 for every accepted word.
- R3: For a half exponent field e in 1..30, the output exponent field (bits 30:23) is e+112. The half mantissa (bits 9:0) appears at output bits 22:13, and output bits 12:0 are 0.
- R4: For a half exponent field of 31, the output exponent field is 255. The half mantissa appears at output bits 22:13, and bits 12:0 are 0. So infinity stays infinity, and a NaN with mantissa bit 9 clear stays signalling.
- R5: A half with exponent and mantissa both zero produces an all-zero exponent and mantissa, with the sign kept.
- R6: A half with exponent 0 and non-zero mantissa m produces a normal single of value m·2^-24. If z is the number of leading zeros of m within 10 bits, the exponent field is 112−z. The bits of m below its leading one fill output bits 22:13 from the top, and the remaining mantissa bits are zero.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_single` stay unchanged.
- R8: `in_ready` is 1 when no word is held or `out_ready` is 1. An accepted word is presented with `out_valid` 1 on the next cycle. A word offered while `in_ready` is 0 is not taken.
- R9: For every non-NaN half pattern, narrowing the output back to half precision returns the original 16-bit pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take the offered word |
| in_half | input | 16 | Half-precision input word |
| out_valid | output | 1 | Output word presented |
| out_ready | input | 1 | Downstream takes the presented word |
| out_single | output | 32 | Single-precision output word |

## Verification
A wrong leading-zero count shows up at the ports as a subnormal output that is off by a power of two. This appears in the very next output beat, so the exhaustive sweep with its round-trip decode exposes it on the first affected pattern.

A state machine stuck in `OR_FULL` or `OR_EMPTY` shows up as one of two port-level faults:
- `in_ready` stays low during a stall release, or
- `out_valid` persists after a drain.

The stall-and-release scenario catches either within one cycle.

A swapped special-case branch corrupts infinities or NaN payloads on the next beat.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
    localparam int HALF_W   = 16;
    localparam int H_EXP_W  = 5;
    localparam int H_MAN_W  = 10;
    localparam int SGL_W    = 32;
    localparam int S_EXP_W  = 8;
    localparam int S_MAN_W  = 23;
    localparam int H_BIAS   = 15;
    localparam int S_BIAS   = 127;
    localparam int REBIAS   = S_BIAS - H_BIAS;
    localparam int MAN_PAD  = S_MAN_W - H_MAN_W;
    localparam int LZ_W     = $clog2(H_MAN_W + 1);

    typedef enum logic [1:0] {
        K_ZERO,
        K_SUB,
        K_NORM,
        K_SPEC
    } kind_t;

    typedef struct packed {
        logic                sign;
        kind_t               kind;
        logic [H_EXP_W-1:0]  exp;
        logic [H_MAN_W-1:0]  man;
        logic [LZ_W-1:0]     lz;
    } half_info_t;
endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
    import h2s_pkg::*;
(
    input  logic [HALF_W-1:0] half_i,
    output half_info_t        info_o
);
    logic [H_EXP_W-1:0] exp_f;
    logic [H_MAN_W-1:0] man_f;
    logic [LZ_W-1:0]    lz_cnt;

    assign exp_f = half_i[HALF_W-2 -: H_EXP_W];
    assign man_f = half_i[H_MAN_W-1:0];

    // Leading-zero count: the highest set bit wins, as the ascending loop overwrites
    always_comb begin
        lz_cnt = LZ_W'(H_MAN_W);
        for (int b = 0; b < H_MAN_W; b++) begin
            if (man_f[b]) lz_cnt = LZ_W'(H_MAN_W - 1 - b);
        end
    end

    always_comb begin
        info_o.sign = half_i[HALF_W-1];
        info_o.exp  = exp_f;
        info_o.man  = man_f;
        info_o.lz   = lz_cnt;
        if (&exp_f)
            info_o.kind = K_SPEC;
        else if (exp_f == '0 && man_f == '0)
            info_o.kind = K_ZERO;
        else if (exp_f == '0)
            info_o.kind = K_SUB;
        else
            info_o.kind = K_NORM;
    end
endmodule

// File: rtl/h2s_assemble.sv
module h2s_assemble
    import h2s_pkg::*;
(
    input  half_info_t       info_i,
    output logic [SGL_W-1:0] word_o
);
    logic [S_EXP_W-1:0] exp_o;
    logic [S_MAN_W-1:0] man_o;
    logic [H_MAN_W-1:0] renorm;

    // Shift the leading one out of the field so it becomes the hidden bit
    assign renorm = info_i.man << (int'(info_i.lz) + 1);

    always_comb begin
        exp_o = '0;
        man_o = '0;
        unique case (info_i.kind)
            K_ZERO: begin
                exp_o = '0;
                man_o = '0;
            end
            K_SUB: begin
                exp_o = S_EXP_W'(REBIAS) - S_EXP_W'(info_i.lz);
                man_o = {renorm, {MAN_PAD{1'b0}}};
            end
            K_NORM: begin
                exp_o = S_EXP_W'(info_i.exp) + S_EXP_W'(REBIAS);
                man_o = {info_i.man, {MAN_PAD{1'b0}}};
            end
            K_SPEC: begin
                exp_o = '1;
                man_o = {info_i.man, {MAN_PAD{1'b0}}};
            end
            default: begin
                exp_o = '0;
                man_o = '0;
            end
        endcase
    end

    assign word_o = {info_i.sign, exp_o, man_o};
endmodule

// File: rtl/h2s_outreg.sv
module h2s_outreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_valid,
    output logic         load_ready,
    input  logic [W-1:0] load_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    typedef enum logic {
        OR_EMPTY,
        OR_FULL
    } or_state_t;

    or_state_t state_q, state_d;
    logic      take;

    assign load_ready = (state_q == OR_EMPTY) || out_ready;
    assign take       = load_valid && load_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OR_EMPTY: if (load_valid)               state_d = OR_FULL;
            OR_FULL:  if (out_ready && !load_valid) state_d = OR_EMPTY;
            default:                                state_d = OR_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OR_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    out_data <= '0;
        else if (take) out_data <= load_data;
    end

    assign out_valid = (state_q == OR_FULL);

    // R7: a stalled word is held unchanged
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/half_to_single_widen.sv
module half_to_single_widen
    import h2s_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HALF_W-1:0] in_half,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SGL_W-1:0]  out_single
);
    half_info_t       info;
    logic [SGL_W-1:0] wide;

    h2s_classify u_classify (
        .half_i (in_half),
        .info_o (info)
    );

    h2s_assemble u_assemble (
        .info_i (info),
        .word_o (wide)
    );

    h2s_outreg #(.W(SGL_W)) u_outreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (in_valid),
        .load_ready (in_ready),
        .load_data  (wide),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_single)
    );

    // R2: sign carried through
    a_r2_sign_carried: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_single[SGL_W-1] == $past(in_half[HALF_W-1])));

    // R4: all-ones exponent keeps payload
    a_r4_special_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (&in_half[HALF_W-2 -: H_EXP_W])) |=>
        ((&out_single[SGL_W-2 -: S_EXP_W]) &&
         out_single[S_MAN_W-1 -: H_MAN_W] == $past(in_half[H_MAN_W-1:0]) &&
         out_single[MAN_PAD-1:0] == '0));

    // R5: signed zero stays zero
    a_r5_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_half[HALF_W-2:0] == '0) |=>
        (out_single[SGL_W-2:0] == '0));

    // R6: subnormal becomes a normal in the narrow exponent window
    a_r6_subnorm_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_half[HALF_W-2 -: H_EXP_W] == '0 &&
         in_half[H_MAN_W-1:0] != '0) |=>
        (out_single[SGL_W-2 -: S_EXP_W] <= S_EXP_W'(REBIAS) &&
         out_single[SGL_W-2 -: S_EXP_W] >= S_EXP_W'(REBIAS - H_MAN_W + 1)));

    // R8: an accepted word is presented next cycle
    a_r8_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: tb/half_to_single_widen_bench.sv
module half_to_single_widen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_half = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_single;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    half_to_single_widen u_half_to_single_widen (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_half(in_half),
        .out_valid(out_valid), .out_ready(out_ready), .out_single(out_single)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Independent model: iterative normalisation by repeated doubling
    function automatic logic [31:0] model(logic [15:0] h);
        logic [7:0]  e;
        logic [10:0] m;
        if (h[14:10] == 5'h1f) return {h[15], 8'hff, h[9:0], 13'b0};
        if (h[14:0] == 15'b0) return {h[15], 31'b0};
        if (h[14:10] != 0) return {h[15], 8'(h[14:10]) + 8'd112, h[9:0], 13'b0};
        e = 8'd113;
        m = {1'b0, h[9:0]};
        while (!m[10]) begin
            m = m << 1;
            e = e - 8'd1;
        end
        return {h[15], e, m[9:0], 13'b0};
    endfunction

    // Narrow an exact single back to half
    function automatic logic [15:0] narrow(logic [31:0] w);
        logic [7:0]  e;
        logic [10:0] full;
        e = w[30:23];
        if (e == 8'd255) return {w[31], 5'h1f, w[22:13]};
        if (e == 0) return {w[31], 15'b0};
        if (e >= 8'd113) return {w[31], 5'(e - 8'd112), w[22:13]};
        full = {1'b1, w[22:13]} >> (8'd113 - e);
        return {w[31], 5'b0, full[9:0]};
    endfunction

    task automatic send_one(logic [15:0] h, output logic [31:0] res);
        @(negedge clk);
        in_valid = 1'b1;
        in_half = h;
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 valid after accept", {31'b0, out_valid}, 32'd1);
        res = out_single;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
        chk("R1 in_ready after reset", {31'b0, in_ready}, 32'd1);
    endtask

    task automatic t_normals();
        logic [31:0] r;
        send_one(16'h3C00, r); chk("R3 one", r, 32'h3F800000);
        send_one(16'hC000, r); chk("R2 R3 minus two", r, 32'hC0000000);
        send_one(16'h7BFF, r); chk("R3 largest normal", r, 32'h477FE000);
        send_one(16'h0400, r); chk("R3 smallest normal", r, 32'h38800000);
    endtask

    task automatic t_specials();
        logic [31:0] r;
        send_one(16'h7C00, r); chk("R4 +inf", r, 32'h7F800000);
        send_one(16'hFC00, r); chk("R4 -inf", r, 32'hFF800000);
        send_one(16'h7C01, r); chk("R4 signalling NaN", r, 32'h7F802000);
        send_one(16'hFE00, r); chk("R4 quiet NaN", r, 32'hFFC00000);
    endtask

    task automatic t_zeros();
        logic [31:0] r;
        send_one(16'h0000, r); chk("R5 +0", r, 32'h00000000);
        send_one(16'h8000, r); chk("R5 -0", r, 32'h80000000);
    endtask

    task automatic t_subnormals();
        logic [31:0] r;
        send_one(16'h0001, r); chk("R6 smallest subnormal", r, 32'h33800000);
        send_one(16'h03FF, r); chk("R6 largest subnormal", r, 32'h387FC000);
        send_one(16'h8200, r); chk("R6 negative top bit", r, 32'hB8000000);
        send_one(16'h0005, r); chk("R6 mid pattern", r, 32'h34A00000);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1;
        in_half = 16'h3C00;
        @(negedge clk);
        in_half = 16'h4000;
        chk("R8 ready low when full and stalled", {31'b0, in_ready}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 held word", out_single, 32'h3F800000);
            chk("R7 held valid", {31'b0, out_valid}, 32'd1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 refill on release", out_single, 32'h40000000);
        @(negedge clk);
        chk("R8 drains to empty", {31'b0, out_valid}, 32'd0);
        chk("R8 ready when empty", {31'b0, in_ready}, 32'd1);
    endtask

    task automatic t_sweep();
        logic [15:0] prev;
        prev = '0;
        out_ready = 1'b1;
        for (int i = 0; i <= 65536; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R9 model match", out_single, model(prev));
                if (prev[14:10] != 5'h1f)
                    chk("R9 round trip", {16'b0, narrow(out_single)}, {16'b0, prev});
            end
            if (i < 65536) begin
                in_valid = 1'b1;
                in_half = 16'(i);
                prev = 16'(i);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_normals();
        t_specials();
        t_zeros();
        t_subnormals();
        t_backpressure();
        t_sweep();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule